// File: doc/BRIEF.md
# Broadcast-Input Weight-Stationary FIR Array

This block is a linear systolic array that evaluates a direct-form FIR filter, y(n) = sum over k of w(k)·x(n−k), for a fixed number of taps. Each processing element holds one signed coefficient, written through a small load port before or between streams. Every accepted input sample is broadcast to all elements in the same cycle. Each element adds its own product to the partial sum arriving from its higher-index neighbour and registers the result. The element at index zero produces the filter output.

The element with the highest index starts its partial sum from zero. A result therefore leaves index zero one cycle after its sample is accepted, and every element performs one multiply-accumulate on every accepted sample. The chain advances only on cycles with a valid input, so gaps in the stream do not disturb the filter history. Samples before reset count as zero. The accumulator is wide enough that the full tap count cannot overflow it.

Top module: `firbc_array`

## Requirements
- R1: After reset `outValid` is low and `outSample` is zero. All coefficients and partial sums are zero.
- R2: `outValid` is high in exactly the cycle after an edge that captured `inValid` high, and low otherwise.
- R3: With `outValid` high, `outSample` equals the sum over k from 0 to TAPS−1 of w(k)·x(n−k). Here x(n) is the sample accepted on the previous edge, x(n−k) is the k-th earlier accepted sample, and samples older than reset are zero.
- R4: A cycle with `inValid` low changes no partial sum. `outSample` keeps its last value and the filter history is unaffected by the gap.
- R5: An edge with `coefWe` high writes `coefData` into element `coefIdx`, which is w(coefIdx). An index of TAPS or above changes no coefficient.
- R6: Data and coefficients are signed two's complement. The result is exact for every input, including all operands at the most negative value.
- R7: A unit impulse followed by zeros produces the outputs w(0), w(1), …, w(TAPS−1) in that order, then zeros.
- R8: A coefficient write affects only products of samples accepted after the write. Partial sums already in the chain keep the products they were formed with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input sample qualifier |
| inSample | input | DATA_W | Signed input sample, broadcast to all elements |
| coefWe | input | 1 | Coefficient write strobe |
| coefIdx | input | $clog2(TAPS+1) | Element index of the coefficient write |
| coefData | input | COEF_W | Signed coefficient value |
| outValid | output | 1 | Result qualifier |
| outSample | output | DATA_W+COEF_W+$clog2(TAPS) | Signed filter result |

## Verification
The bench builds the array with TAPS=5, DATA_W=8 and COEF_W=8. The odd tap count gives a 3-bit index field, so indices 5 to 7 exercise the ignored-write path. The narrow words make the most negative operand on every tap reachable with a short stimulus, which checks the widened accumulator at its extreme. A scoreboard model keeps, for each accepted sample, the coefficients in force when that sample was accepted. This makes it possible to check mid-stream coefficient writes against R8 as well as stall gaps of varying length.

// File: rtl/firbc_pkg.sv
package firbc_pkg;

  // Strobes from control to datapath, one bit each.
  typedef struct packed {
    logic advance;   // accepted sample: every element accumulates
    logic coefLoad;  // coefficient write request this cycle
  } firbc_strobe_t;

endpackage

// File: rtl/firbc_ctrl.sv
module firbc_ctrl
  import firbc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          coefWe,
  output firbc_strobe_t strobes,
  output logic          outValid
);

  always_comb begin
    strobes.advance  = inValid;
    strobes.coefLoad = coefWe;
  end

  // One register stage between sample capture and result at element 0.
  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);   // R2
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2

endmodule

// File: rtl/firbc_pe.sv
module firbc_pe #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 35
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     advance,
  input  logic                     coefLoad,
  input  logic signed [COEF_W-1:0] coefData,
  input  logic signed [DATA_W-1:0] xBcast,
  input  logic signed [ACC_W-1:0]  sumIn,
  output logic signed [ACC_W-1:0]  sumOut,
  output logic signed [COEF_W-1:0] coefOut
);

  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [COEF_W-1:0] coefReg;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt;

  always_comb begin
    prod    = xBcast * coefReg;
    prodExt = ACC_W'(prod);
  end

  // Resident coefficient.
  always_ff @(posedge clk) begin
    if (!rstN)         coefReg <= '0;
    else if (coefLoad) coefReg <= coefData;
  end

  // One register per hop on the partial-sum path.
  always_ff @(posedge clk) begin
    if (!rstN)        sumOut <= '0;
    else if (advance) sumOut <= sumIn + prodExt;
  end

  assign coefOut = coefReg;

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(sumOut));  // R4
  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !coefLoad |=> $stable(coefOut)); // R5

endmodule

// File: rtl/firbc_datapath.sv
module firbc_datapath
  import firbc_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 35,
  parameter int IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  firbc_strobe_t            strobes,
  input  logic [IDX_W-1:0]         coefIdx,
  input  logic signed [COEF_W-1:0] coefData,
  input  logic signed [DATA_W-1:0] xBcast,
  output logic signed [ACC_W-1:0]  resultSum
);

  logic signed [ACC_W-1:0] chain [TAPS+1];
  logic [TAPS-1:0][COEF_W-1:0] coefBus;

  // Far end of the chain starts from zero.
  assign chain[TAPS] = '0;

  for (genvar j = 0; j < TAPS; j++) begin : gPe
    logic loadHere;
    assign loadHere = strobes.coefLoad && (coefIdx == IDX_W'(j));

    firbc_pe #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .ACC_W (ACC_W)
    ) pe_i (
      .clk     (clk),
      .rstN    (rstN),
      .advance (strobes.advance),
      .coefLoad(loadHere),
      .coefData(coefData),
      .xBcast  (xBcast),
      .sumIn   (chain[j+1]),
      .sumOut  (chain[j]),
      .coefOut (coefBus[j])
    );
  end

  assign resultSum = chain[0];

  AST_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.coefLoad && coefIdx >= IDX_W'(TAPS)) |=> $stable(coefBus)); // R5

endmodule

// File: rtl/firbc_array.sv
module firbc_array
  import firbc_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int IDX_W = $clog2(TAPS + 1),
  localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic                     coefWe,
  input  logic [IDX_W-1:0]         coefIdx,
  input  logic signed [COEF_W-1:0] coefData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outSample
);

  firbc_strobe_t strobes;

  firbc_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .coefWe  (coefWe),
    .strobes (strobes),
    .outValid(outValid)
  );

  firbc_datapath #(
    .TAPS  (TAPS),
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .ACC_W (ACC_W),
    .IDX_W (IDX_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .coefIdx  (coefIdx),
    .coefData (coefData),
    .xBcast   (inSample),
    .resultSum(outSample)
  );

endmodule

// File: tb/firbc_array_tb_top.sv
module firbc_array_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TAPS   = 5;
  localparam int DATA_W = 8;
  localparam int COEF_W = 8;
  localparam int IDX_W  = $clog2(TAPS + 1);
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DATA_W-1:0] inSample = '0;
  logic coefWe = 1'b0;
  logic [IDX_W-1:0] coefIdx = '0;
  logic signed [COEF_W-1:0] coefData = '0;
  logic outValid;
  logic signed [ACC_W-1:0] outSample;

  firbc_array #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .coefWe(coefWe), .coefIdx(coefIdx), .coefData(coefData),
    .outValid(outValid), .outSample(outSample)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  longint expQ[$];
  string  tagQ[$];

  // Model state: coefficients in force now, and per accepted sample the
  // sample value with a snapshot of the coefficients it was multiplied by.
  int coefModel [TAPS];
  int xHist [TAPS];
  int cHist [TAPS][TAPS];

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendSample(input int x, input string tag);
    longint e;
    @(negedge clk);
    coefWe   = 1'b0;
    inValid  = 1'b1;
    inSample = DATA_W'(x);
    for (int k = TAPS - 1; k > 0; k--) begin
      xHist[k] = xHist[k-1];
      for (int m = 0; m < TAPS; m++) cHist[k][m] = cHist[k-1][m];
    end
    xHist[0] = x;
    for (int m = 0; m < TAPS; m++) cHist[0][m] = coefModel[m];
    e = 0;
    for (int k = 0; k < TAPS; k++) e += longint'(xHist[k]) * longint'(cHist[k][k]);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      coefWe  = 1'b0;
    end
  endtask

  task automatic loadCoef(input int idx, input int val);
    @(negedge clk);
    inValid  = 1'b0;
    coefWe   = 1'b1;
    coefIdx  = IDX_W'(idx);
    coefData = COEF_W'(val);
    if (idx < TAPS) coefModel[idx] = val;
  endtask

  // Monitor: just after each edge, outputs have settled and inputs still
  // hold the values that edge captured.
  logic seenOut = 1'b0;
  longint lastOut = 0;
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      check("R2 outValid follows inValid", longint'(outValid), longint'(inValid));
      if (outValid) begin
        if (expQ.size() == 0) begin
          check("R3 unexpected result", 1, 0);
        end else begin
          longint e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, longint'(outSample), e);
        end
        seenOut = 1'b1;
        lastOut = longint'(outSample);
      end else if (seenOut) begin
        check("R4 output held during gap", longint'(outSample), lastOut);
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lfsr;
    for (int k = 0; k < TAPS; k++) begin
      coefModel[k] = 0;
      xHist[k] = 0;
      for (int m = 0; m < TAPS; m++) cHist[k][m] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 outValid after reset", longint'(outValid), 0);
    check("R1 outSample after reset", longint'(outSample), 0);

    // Zero coefficients after reset give zero output.
    sendSample(77, "R1 zero coefficients");
    idle(2);

    // R5: load coefficients.
    loadCoef(0, 3);
    loadCoef(1, -2);
    loadCoef(2, 5);
    loadCoef(3, 7);
    loadCoef(4, -1);
    idle(1);

    // R7: impulse response.
    sendSample(1, "R7 impulse response");
    for (int i = 0; i < TAPS + 1; i++) sendSample(0, "R7 impulse response");
    idle(2);

    // R3: back-to-back pseudo-random stream.
    lfsr = 32'h1d;
    for (int i = 0; i < 24; i++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      sendSample((lfsr >>> 8) % 256 - 128, "R3 streaming convolution");
    end

    // R4: stream with gaps of varying length.
    for (int i = 0; i < 12; i++) begin
      sendSample(i * 11 - 60, "R4 history across gaps");
      idle(i % 4);
    end

    // R5: out-of-range index writes must leave coefficients unchanged.
    loadCoef(5, 99);
    loadCoef(7, -99);
    idle(1);
    sendSample(1, "R5 ignored index write");
    for (int i = 0; i < TAPS; i++) sendSample(0, "R5 ignored index write");

    // R8: coefficient change in the middle of a stream.
    for (int i = 0; i < 3; i++) sendSample(20 + i, "R8 before coefficient write");
    loadCoef(1, 9);
    loadCoef(4, 6);
    for (int i = 0; i < 7; i++) sendSample(-5 + i, "R8 after coefficient write");
    idle(2);

    // R6: most negative operands on every tap.
    for (int k = 0; k < TAPS; k++) loadCoef(k, -128);
    for (int i = 0; i < TAPS + 1; i++) sendSample(-128, "R6 extreme negative");
    for (int i = 0; i < TAPS; i++) sendSample(127, "R6 extreme mixed");
    for (int i = 0; i < TAPS; i++) sendSample((i % 2 == 0) ? 127 : -128, "R6 alternating extremes");
    idle(4);

    check("R3 all results produced", longint'(expQ.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule